// File: doc/BRIEF.md
# DDR Command Interval Guard

This block sits between a DDR command scheduler and the memory interface. It enforces the minimum number of clock cycles that must pass between certain commands. Each cycle the scheduler offers at most one command: a self-refresh exit, a read, a precharge, a clock-enable toggle, or any other command. In the same cycle the guard answers with a grant or a stall. A stalled command must be held by the scheduler until it is granted.

Four spacing limits come from one 32-bit timing word. Each field holds the required cycle count minus one. The word can be rewritten only while an unlock input is high.

When a triggering command is granted, the matching countdown window loads the field value that is current in that cycle. A command that depends on that window is stalled until the window reaches zero. So a field value of N gives a spacing of N+1 cycles between the two grants. A later rewrite of the word does not change a window that is already running.

Top module: `ddr_cmd_interval_guard`

## Requirements
- R1: In the cycle after a synchronous reset, the timing word reads 0x001DF145, and the first precharge, other, clock-enable and read requests are granted at once.
- R2: A write while `cfg_unlock` is 1 stores the fields, and the new value can be read back in the next cycle. The field positions are:
  - [22:16]: self-refresh exit to non-read
  - [15:8]: self-refresh exit to read
  - [7:5]: read to precharge
  - [4:0]: clock-enable spacing

  Bits 31:23 always read 0.
- R3: A write while `cfg_unlock` is 0 leaves the timing word unchanged.
- R4: The command codes are:
  - 0: self-refresh exit
  - 1: read
  - 2: precharge
  - 3: other
  - 4: clock-enable toggle
  - 5 to 7: treated as other

  With `req_valid` high, exactly one of `grant` and `stall` is high. With `req_valid` low, both are low.
- R5: After a granted self-refresh exit, precharge and other commands are stalled until the [22:16] field value plus one cycles have passed.
- R6: After a granted self-refresh exit, reads are stalled until the [15:8] field value plus one cycles have passed.
- R7: After a granted read, precharge is stalled until the [7:5] field value plus one cycles have passed.
- R8: Two granted clock-enable transitions are at least the [4:0] field value plus one cycles apart. A self-refresh exit counts as such a transition.
- R9: A timing write that lands while a window is running does not shorten or lengthen that window. The new value applies from the next triggering grant.
- R10: A request whose windows are all clear is granted in the same cycle it is presented, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_unlock | input | 1 | Enables timing-word writes when 1 |
| cfg_wr_en | input | 1 | Timing-word write strobe |
| cfg_wr_data | input | 32 | Timing word to write |
| cfg_rd_data | output | 32 | Current timing word |
| req_valid | input | 1 | A command is offered this cycle |
| req_cmd | input | 3 | Offered command code |
| grant | output | 1 | Offered command may issue this cycle |
| stall | output | 1 | Offered command must be held |

## Verification
Grant and stall depend combinationally on the offered command and on the window state, so they are sampled in the same cycle the request is driven, before the next rising edge. A window started by a grant in cycle t blocks its dependent commands through cycle t+N and releases them in cycle t+N+1. The bench computes this from cycle stamps and from the field value it had programmed at the time of the trigger.

A timing write shows up on `cfg_rd_data` one cycle after its edge, and the readback is compared there. Sweeps cover a grid of small field values with random held-until-granted command streams. Directed runs cover reset values, locked writes and a rewrite in the middle of a window.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    localparam int WORD_W    = 32;
    localparam int CMD_W     = 3;
    localparam int XSNR_W    = 7;
    localparam int XSRD_W    = 8;
    localparam int RTP_W     = 3;
    localparam int CKE_W     = 5;
    localparam int XSNR_LSB  = 16;
    localparam int XSRD_LSB  = 8;
    localparam int RTP_LSB   = 5;
    localparam int CKE_LSB   = 0;

    typedef enum logic [CMD_W-1:0] {
        CMD_SR_EXIT   = 3'd0,
        CMD_READ      = 3'd1,
        CMD_PRECHARGE = 3'd2,
        CMD_OTHER     = 3'd3,
        CMD_CKE       = 3'd4
    } cmd_e;

    typedef struct packed {
        logic [XSNR_W-1:0] xsnr;
        logic [XSRD_W-1:0] xsrd;
        logic [RTP_W-1:0]  rtp;
        logic [CKE_W-1:0]  cke;
    } timing_t;

    typedef struct packed {
        logic sr_exit;
        logic rd;
        logic pre;
        logic oth;
        logic cke;
    } cmd_dec_t;

    localparam timing_t TIMING_RST = '{xsnr: 7'h1D, xsrd: 8'hF1, rtp: 3'h2, cke: 5'h05};

    function automatic timing_t unpack_timing(input logic [WORD_W-1:0] w);
        timing_t t;
        t.xsnr = w[XSNR_LSB +: XSNR_W];
        t.xsrd = w[XSRD_LSB +: XSRD_W];
        t.rtp  = w[RTP_LSB  +: RTP_W];
        t.cke  = w[CKE_LSB  +: CKE_W];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] pack_timing(input timing_t t);
        logic [WORD_W-1:0] w;
        w = '0;
        w[XSNR_LSB +: XSNR_W] = t.xsnr;
        w[XSRD_LSB +: XSRD_W] = t.xsrd;
        w[RTP_LSB  +: RTP_W]  = t.rtp;
        w[CKE_LSB  +: CKE_W]  = t.cke;
        return w;
    endfunction

    function automatic cmd_dec_t decode_cmd(input logic [CMD_W-1:0] c);
        cmd_dec_t d;
        d = '0;
        case (c)
            CMD_SR_EXIT:   d.sr_exit = 1'b1;
            CMD_READ:      d.rd      = 1'b1;
            CMD_PRECHARGE: d.pre     = 1'b1;
            CMD_CKE:       d.cke     = 1'b1;
            default:       d.oth     = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ddr_guard_regs.sv
module ddr_guard_regs
    import ddr_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output timing_t           timing,
    output logic [WORD_W-1:0] rd_data
);

    timing_t timing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timing_q <= TIMING_RST;
        end else if (wr_en && unlock) begin
            timing_q <= unpack_timing(wr_data);
        end
    end

    assign timing  = timing_q;
    assign rd_data = pack_timing(timing_q);

    // R1: reset leaves the documented default word
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (timing_q == TIMING_RST));

    // R3: a write without unlock is dropped
    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && unlock) |=> $stable(timing_q));

    // R2: an unlocked write lands in the fields
    a_r2_unlocked_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unlock) |=> (rd_data[XSNR_LSB+XSNR_W-1:0] == $past(wr_data[XSNR_LSB+XSNR_W-1:0])));

endmodule

// File: rtl/ddr_guard_window.sv
module ddr_guard_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign busy = (cnt_q != '0);

    // R9: a window takes the field value present at its trigger
    a_r9_load_captures_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R5: a running window drops by one each cycle until reloaded
    a_r5_window_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> ((cnt_q + W'(1)) == $past(cnt_q)));

    // R10: an idle window stays idle without a trigger
    a_r10_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> !busy);

endmodule

// File: rtl/ddr_guard_gate.sv
module ddr_guard_gate
    import ddr_guard_pkg::*;
(
    input  logic     req_valid,
    input  cmd_dec_t dec,
    input  logic     xsnr_busy,
    input  logic     xsrd_busy,
    input  logic     rtp_busy,
    input  logic     cke_busy,
    output logic     grant,
    output logic     stall,
    output logic     ld_xsnr,
    output logic     ld_xsrd,
    output logic     ld_rtp,
    output logic     ld_cke
);

    logic permit;

    always_comb begin
        permit = 1'b1;
        if (dec.sr_exit) permit = !cke_busy;
        if (dec.rd)      permit = !xsrd_busy;
        if (dec.pre)     permit = !xsnr_busy && !rtp_busy;
        if (dec.oth)     permit = !xsnr_busy;
        if (dec.cke)     permit = !cke_busy;
    end

    assign grant   = req_valid && permit;
    assign stall   = req_valid && !permit;
    assign ld_xsnr = grant && dec.sr_exit;
    assign ld_xsrd = grant && dec.sr_exit;
    assign ld_rtp  = grant && dec.rd;
    assign ld_cke  = grant && (dec.sr_exit || dec.cke);

endmodule

// File: rtl/ddr_cmd_interval_guard.sv
module ddr_cmd_interval_guard
    import ddr_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_unlock,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        req_valid,
    input  logic [2:0]  req_cmd,
    output logic        grant,
    output logic        stall
);

    timing_t  timing;
    cmd_dec_t dec;
    logic     xsnr_busy, xsrd_busy, rtp_busy, cke_busy;
    logic     ld_xsnr, ld_xsrd, ld_rtp, ld_cke;

    assign dec = decode_cmd(req_cmd);

    ddr_guard_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .unlock  (cfg_unlock),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .timing  (timing),
        .rd_data (cfg_rd_data)
    );

    ddr_guard_window #(.W(XSNR_W)) win_xsnr_i (
        .clk (clk), .rst (rst), .load (ld_xsnr), .load_val (timing.xsnr), .busy (xsnr_busy)
    );

    ddr_guard_window #(.W(XSRD_W)) win_xsrd_i (
        .clk (clk), .rst (rst), .load (ld_xsrd), .load_val (timing.xsrd), .busy (xsrd_busy)
    );

    ddr_guard_window #(.W(RTP_W)) win_rtp_i (
        .clk (clk), .rst (rst), .load (ld_rtp), .load_val (timing.rtp), .busy (rtp_busy)
    );

    ddr_guard_window #(.W(CKE_W)) win_cke_i (
        .clk (clk), .rst (rst), .load (ld_cke), .load_val (timing.cke), .busy (cke_busy)
    );

    ddr_guard_gate gate_i (
        .req_valid (req_valid),
        .dec       (dec),
        .xsnr_busy (xsnr_busy),
        .xsrd_busy (xsrd_busy),
        .rtp_busy  (rtp_busy),
        .cke_busy  (cke_busy),
        .grant     (grant),
        .stall     (stall),
        .ld_xsnr   (ld_xsnr),
        .ld_xsrd   (ld_xsrd),
        .ld_rtp    (ld_rtp),
        .ld_cke    (ld_cke)
    );

    // R4: answers only to a valid request, and exactly one of them
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!grant && !stall));
    a_r4_one_answer: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (grant != stall));

    // R5: no non-read command right after a self-refresh exit with a nonzero field
    a_r5_no_other_after_exit: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 3'd0 && timing.xsnr != '0) |=> !(grant && req_cmd == 3'd3));

    // R6: no read right after a self-refresh exit with a nonzero field
    a_r6_no_read_after_exit: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 3'd0 && timing.xsrd != '0) |=> !(grant && req_cmd == 3'd1));

    // R7: no precharge right after a read with a nonzero field
    a_r7_no_pre_after_read: assert property (@(posedge clk) disable iff (rst)
        (grant && req_cmd == 3'd1 && timing.rtp != '0) |=> !(grant && req_cmd == 3'd2));

    // R8: clock-enable transitions are never back to back with a nonzero field
    a_r8_cke_spacing: assert property (@(posedge clk) disable iff (rst)
        (grant && (req_cmd == 3'd4 || req_cmd == 3'd0) && timing.cke != '0)
            |=> !(grant && (req_cmd == 3'd4 || req_cmd == 3'd0)));

endmodule

// File: tb/ddr_cmd_interval_guard_tb.sv
`timescale 1ns/1ps
module ddr_cmd_interval_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_unlock = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = '0;
    logic        grant, stall;

    always #10 clk = ~clk;

    ddr_cmd_interval_guard dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_unlock  (cfg_unlock),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .grant       (grant),
        .stall       (stall)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench shadow of the timing word
    int sh_xsnr, sh_xsrd, sh_rtp, sh_cke;
    // event stamps and the limits captured at each trigger
    int now_cyc;
    bit srx_seen, rd_seen, cke_seen;
    int srx_cyc, rd_cyc, cke_cyc;
    int lim_nr, lim_rd, lim_rtp, lim_cke;
    bit last_stalled;
    int last_cmd;

    function automatic logic [31:0] shadow_word();
        return (32'(sh_xsnr) << 16) | (32'(sh_xsrd) << 8) | (32'(sh_rtp) << 5) | 32'(sh_cke);
    endfunction

    function automatic string tag_for(int c);
        case (c)
            0: return "R8";
            1: return "R6";
            2: return "R7";
            4: return "R8";
            default: return "R5";
        endcase
    endfunction

    function automatic bit model_ok(int c);
        bit nr_ok, rd_ok, rtp_ok, cke_ok;
        nr_ok  = !srx_seen || (now_cyc - srx_cyc) >= lim_nr + 1;
        rd_ok  = !srx_seen || (now_cyc - srx_cyc) >= lim_rd + 1;
        rtp_ok = !rd_seen  || (now_cyc - rd_cyc)  >= lim_rtp + 1;
        cke_ok = !cke_seen || (now_cyc - cke_cyc) >= lim_cke + 1;
        case (c)
            0: return cke_ok;
            1: return rd_ok;
            2: return nr_ok && rtp_ok;
            4: return cke_ok;
            default: return nr_ok;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, what, act, exp, now_cyc);
        end
    endtask

    // one clock: drive at negedge, check before the edge, update model at the edge
    task automatic do_cycle(input bit v, input int c, input string tag);
        bit exp_g;
        bit wr;
        string t;
        req_valid = v;
        req_cmd   = 3'(c);
        #1;
        exp_g = v && model_ok(c);
        t = (tag.len() != 0) ? tag : (v ? tag_for(c) : "R4");
        check(grant == exp_g, t, "grant", 32'(grant), 32'(exp_g));
        check(stall == (v && !exp_g), "R4", "stall", 32'(stall), 32'(v && !exp_g));
        last_stalled = v && !exp_g;
        last_cmd = c;
        wr = cfg_wr_en && cfg_unlock;
        if (exp_g) begin
            if (c == 0) begin
                srx_seen = 1; srx_cyc = now_cyc; lim_nr = sh_xsnr; lim_rd = sh_xsrd;
                cke_seen = 1; cke_cyc = now_cyc; lim_cke = sh_cke;
            end else if (c == 1) begin
                rd_seen = 1; rd_cyc = now_cyc; lim_rtp = sh_rtp;
            end else if (c == 4) begin
                cke_seen = 1; cke_cyc = now_cyc; lim_cke = sh_cke;
            end
        end
        @(posedge clk);
        now_cyc++;
        if (wr) begin
            sh_xsnr = int'(cfg_wr_data[22:16]);
            sh_xsrd = int'(cfg_wr_data[15:8]);
            sh_rtp  = int'(cfg_wr_data[7:5]);
            sh_cke  = int'(cfg_wr_data[4:0]);
        end
        @(negedge clk);
        cfg_wr_en = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic check_readback(input string tag);
        check(cfg_rd_data == shadow_word(), tag, "readback", cfg_rd_data, shadow_word());
    endtask

    task automatic write_word(input logic [31:0] w, input bit unl, input bit v, input int c, input string tag);
        cfg_wr_data = w;
        cfg_unlock  = unl;
        cfg_wr_en   = 1'b1;
        do_cycle(v, c, tag);
        cfg_unlock  = 1'b0;
    endtask

    task automatic random_stream(input int n);
        for (int i = 0; i < n; i++) begin
            int c;
            bit v;
            if (last_stalled) begin
                v = 1; c = last_cmd;
            end else begin
                v = ($urandom % 4) != 0;
                c = int'($urandom % 8);
            end
            do_cycle(v, c, "");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        sh_xsnr = 'h1D; sh_xsrd = 'hF1; sh_rtp = 2; sh_cke = 5;
        now_cyc = 0; srx_seen = 0; rd_seen = 0; cke_seen = 0;
        srx_cyc = 0; rd_cyc = 0; cke_cyc = 0;
        lim_nr = 0; lim_rd = 0; lim_rtp = 0; lim_cke = 0;
        last_stalled = 0; last_cmd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset word and immediate grants
        check(cfg_rd_data == 32'h001DF145, "R1", "reset word", cfg_rd_data, 32'h001DF145);
        check(shadow_word() == 32'h001DF145, "R1", "bench reset word", shadow_word(), 32'h001DF145);
        do_cycle(1, 2, "R1");
        do_cycle(1, 3, "R1");
        do_cycle(1, 4, "R1");
        do_cycle(1, 1, "R1");
        do_cycle(0, 0, "R4");
        do_cycle(1, 7, "R4");

        // R3: locked write dropped
        write_word(32'hFFFF_FFFF, 1'b0, 0, 0, "R4");
        check(cfg_rd_data == 32'h001DF145, "R3", "locked write", cfg_rd_data, 32'h001DF145);

        // R6 and R5 with default fields: exit, then hold a read, then others
        repeat (8) do_cycle(0, 0, "R4");
        do_cycle(1, 0, "R8");
        while (last_stalled || now_cyc - srx_cyc < 2) do_cycle(1, 1, "R6");
        random_stream(60);

        // R9: rewrite while a window runs; running window keeps old length
        while (last_stalled) do_cycle(1, last_cmd, "");
        write_word(32'h000A_0000, 1'b1, 0, 0, "R4");
        check_readback("R2");
        while (!model_ok(0)) do_cycle(0, 0, "R4");
        do_cycle(1, 0, "R8");
        write_word(32'h0000_0000, 1'b1, 1, 3, "R9");
        check_readback("R2");
        for (int i = 0; i < 12; i++) do_cycle(1, 3, "R9");

        // sweep over a grid of small field values with random streams
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                for (int r = 0; r < 3; r++) begin
                    for (int k = 0; k < 3; k++) begin
                        int vx, vr, vp, vk;
                        logic [31:0] w;
                        vx = (a == 0) ? 0 : (a == 1) ? 3 : 6;
                        vr = (b == 0) ? 0 : (b == 1) ? 2 : 9;
                        vp = (r == 0) ? 0 : (r == 1) ? 1 : 7;
                        vk = (k == 0) ? 0 : (k == 1) ? 4 : 31;
                        w = (32'(vx) << 16) | (32'(vr) << 8) | (32'(vp) << 5) | 32'(vk);
                        w = w | ({$urandom} & 32'hFF80_0000);
                        while (last_stalled) do_cycle(1, last_cmd, "");
                        write_word(w, 1'b1, 0, 0, "R4");
                        check_readback("R2");
                        write_word($urandom, 1'b0, 0, 0, "R4");
                        check_readback("R3");
                        random_stream(50);
                    end
                end
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule